// File: doc/BRIEF.md
# Palette Pixel Depth Expander

This block converts a stream of packed frame-buffer bytes into 24-bit RGB pixels. Bytes enter through a valid/ready port. Pixels leave through a second valid/ready port, one pixel per cycle at most. A 256-entry palette of 12-bit colours is loaded through a separate write port. The depth of the packed data is taken from bits 14:12 of the word written to palette entry 0. At 2, 4 and 8 bits per pixel the packed value selects a palette colour. At 16 bits per pixel the halfword is decoded directly, either as 4:4:4 or as 5:6:5 depending on a panel-type input.

Within a byte, pixels are unpacked starting from the least significant bits. Each 12-bit colour is widened by placing every nibble in the upper half of its 8-bit channel. The unpacking pauses while the sink is not ready, and no pixel is dropped. Fetching the frame buffer and generating display timing are handled by other blocks.

Top module: `depth_expander`

## Requirements
- R1: The depth code is bits 14:12 of the last word written to palette address 0, and it is 0 after reset. Code 1 selects 2 bpp, code 2 selects 4 bpp and code 3 selects 8 bpp. Codes 4, 5, 6 and 7 all select 16 bpp.
- R2: With depth code 0, every offered byte is accepted in the cycle it is offered and `pixValid` never asserts.
- R3: At 2 bpp each byte yields four pixels. The pixels come from bits 1:0, 3:2, 5:4 and 7:6 in that order, and each 2-bit value indexes palette entries 0 to 3.
- R4: At 4 bpp each byte yields two pixels. The first comes from bits 3:0 and the second from bits 7:4, and each value indexes palette entries 0 to 15.
- R5: At 8 bpp each byte yields one pixel, and the byte indexes any of the 256 palette entries.
- R6: A palette colour c maps to pixRgb = {c[11:8],4'h0, c[7:4],4'h0, c[3:0],4'h0}, which is red, green, blue from the top bits down. The low nibble of each channel is therefore zero.
- R7: At 16 bpp, two input bytes form one halfword with the first byte as bits 7:0. A lone first byte produces no pixel. With `tftMode` low, the halfword bits 11:0 are expanded as in R6.
- R8: At 16 bpp with `tftMode` high, pixRgb = {h[15:11],3'b0, h[10:5],2'b0, h[4:0],3'b0}.
- R9: While `pixValid` is high and `pixReady` is low, `pixValid` stays high and `pixRgb` holds its value. Every pixel implied by the accepted input is delivered once, in order.
- R10: After reset, `pixValid` is low.
- R11: At 8 bpp with `pixReady` held high, `inReady` is high in every cycle, so one byte is accepted and one pixel is delivered per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| palWrEn | input | 1 | Palette write strobe |
| palWrAddr | input | 8 | Palette entry to write |
| palWrData | input | 16 | Palette word: colour in 11:0, depth code in 14:12 (used at address 0) |
| tftMode | input | 1 | Selects 5:6:5 decoding at 16 bpp |
| inData | input | 8 | Packed frame-buffer byte |
| inValid | input | 1 | Input byte is offered |
| inReady | output | 1 | Input byte is taken this cycle |
| pixRgb | output | 24 | Output pixel, red in 23:16, green in 15:8, blue in 7:0 |
| pixValid | output | 1 | Output pixel is offered |
| pixReady | input | 1 | Sink takes the pixel this cycle |

## Verification
The assertions check, on every cycle, the properties that do not depend on data. A stalled pixel must hold its value. A palette-derived pixel must have zero low nibbles. The unpack slot must stay within range for the active depth. A depth code of 0 or a lone low byte must never start a pixel. A write to entry 0 must update the depth code. Input must be taken on the cycle the last pixel of a byte leaves. Only the bench scenarios can show the actual pixel values and their order. They sweep every byte value at each palette depth, a wide range of halfwords in both 16-bit decodings, and every code that maps to 16 bpp, all against a palette model. The same scenarios check that no pixel is lost or duplicated under irregular backpressure.

// File: rtl/pxe_pkg.sv
`timescale 1ns/1ps
package pxe_pkg;

  typedef enum logic [2:0] {
    DEP_NONE = 3'd0,
    DEP_2    = 3'd1,
    DEP_4    = 3'd2,
    DEP_8    = 3'd3,
    DEP_16   = 3'd4
  } depth_e;

  typedef struct packed {
    logic       loadWord;
    logic       loadLow;
    logic [1:0] slot;
  } strobe_t;

  function automatic depth_e decodeDepth(input logic [2:0] code);
    case (code)
      3'd0:    return DEP_NONE;
      3'd1:    return DEP_2;
      3'd2:    return DEP_4;
      3'd3:    return DEP_8;
      default: return DEP_16;
    endcase
  endfunction

  function automatic logic [1:0] lastSlotOf(input depth_e kind);
    case (kind)
      DEP_2:   return 2'd3;
      DEP_4:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [23:0] widen444(input logic [11:0] c);
    return {c[11:8], 4'h0, c[7:4], 4'h0, c[3:0], 4'h0};
  endfunction

  function automatic logic [23:0] widen565(input logic [15:0] h);
    return {h[15:11], 3'b000, h[10:5], 2'b00, h[4:0], 3'b000};
  endfunction

endpackage

// File: rtl/pxe_ctrl.sv
`timescale 1ns/1ps
module pxe_ctrl
  import pxe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] depthCode,
  input  logic       inValid,
  input  logic       pixReady,
  output logic       inReady,
  output logic       pixValid,
  output strobe_t    strobe
);

  depth_e     kind;
  logic [1:0] lastIdx;
  logic       busy;
  logic [1:0] slot;
  logic       haveLow;
  logic       fire;
  logic       lastSlot;
  logic       freeSlot;
  logic       accept;

  always_comb begin
    kind     = decodeDepth(depthCode);
    lastIdx  = lastSlotOf(kind);
    fire     = busy && pixReady;
    lastSlot = (slot == lastIdx);
    freeSlot = !busy || (fire && lastSlot);
    case (kind)
      DEP_NONE: inReady = 1'b1;
      DEP_16:   inReady = haveLow ? freeSlot : 1'b1;
      default:  inReady = freeSlot;
    endcase
    accept          = inValid && inReady;
    strobe.loadWord = accept && (kind != DEP_NONE) && ((kind != DEP_16) || haveLow);
    strobe.loadLow  = accept && (kind == DEP_16) && !haveLow;
    strobe.slot     = slot;
  end

  assign pixValid = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      slot    <= 2'd0;
      haveLow <= 1'b0;
    end else begin
      if (strobe.loadWord) begin
        busy <= 1'b1;
        slot <= 2'd0;
      end else if (fire) begin
        if (lastSlot) begin
          busy <= 1'b0;
          slot <= 2'd0;
        end else begin
          slot <= slot + 2'd1;
        end
      end
      if (strobe.loadLow)       haveLow <= 1'b1;
      else if (strobe.loadWord) haveLow <= 1'b0;
    end
  end

  // R3: unpack position never leaves the range of the active depth
  p_slot_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (slot <= lastIdx));

  // R2: an idle block with code 0 never starts a pixel
  p_none_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    (kind == DEP_NONE) && !busy |=> !busy);

  // R7: a lone first byte of a halfword does not start a pixel
  p_pair_needed_r7: assert property (@(posedge clk) disable iff (!rstN)
    (kind == DEP_16) && !haveLow && !busy |=> !busy);

  // R11: input is taken in the cycle the final pixel of a byte leaves
  p_ready_on_last_r11: assert property (@(posedge clk) disable iff (!rstN)
    fire && lastSlot && (kind != DEP_16) && (kind != DEP_NONE) |-> inReady);

endmodule

// File: rtl/pxe_datapath.sv
`timescale 1ns/1ps
module pxe_datapath
  import pxe_pkg::*;
#(
  parameter int PAL_AW  = 8,
  parameter int PWORD_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               palWrEn,
  input  logic [PAL_AW-1:0]  palWrAddr,
  input  logic [PWORD_W-1:0] palWrData,
  input  logic [7:0]         inData,
  input  logic               tftMode,
  input  strobe_t            strobe,
  output logic [2:0]         depthCode,
  output logic [23:0]        pixRgb
);

  localparam int PAL_N = 1 << PAL_AW;

  logic [11:0]       palMem [PAL_N];
  logic [7:0]        lowByte;
  logic [15:0]       word;
  depth_e            kind;
  logic [7:0]        rawIdx;
  logic [PAL_AW-1:0] idx;
  logic [11:0]       palColor;

  always_ff @(posedge clk) begin
    if (palWrEn) palMem[palWrAddr] <= palWrData[11:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthCode <= 3'd0;
      lowByte   <= 8'h00;
      word      <= 16'h0000;
    end else begin
      if (palWrEn && (palWrAddr == '0)) depthCode <= palWrData[14:12];
      if (strobe.loadLow) lowByte <= inData;
      if (strobe.loadWord) begin
        word[15:8] <= inData;
        word[7:0]  <= (kind == DEP_16) ? lowByte : inData;
      end
    end
  end

  always_comb begin
    kind = decodeDepth(depthCode);
    case (kind)
      DEP_2:   rawIdx = {6'b0, word[{strobe.slot, 1'b0} +: 2]};
      DEP_4:   rawIdx = {4'b0, word[{strobe.slot[0], 2'b00} +: 4]};
      default: rawIdx = word[7:0];
    endcase
    idx      = PAL_AW'(rawIdx);
    palColor = palMem[idx];
    if (kind == DEP_16) begin
      pixRgb = tftMode ? widen565(word) : widen444(word[11:0]);
    end else begin
      pixRgb = widen444(palColor);
    end
  end

  // R1: a write to entry 0 sets the depth code from bits 14:12
  p_code_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    palWrEn && (palWrAddr == '0) |=> depthCode == $past(palWrData[14:12]));

endmodule

// File: rtl/depth_expander.sv
`timescale 1ns/1ps
module depth_expander
  import pxe_pkg::*;
#(
  parameter int PAL_AW  = 8,
  parameter int PWORD_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               palWrEn,
  input  logic [PAL_AW-1:0]  palWrAddr,
  input  logic [PWORD_W-1:0] palWrData,
  input  logic               tftMode,
  input  logic [7:0]         inData,
  input  logic               inValid,
  output logic               inReady,
  output logic [23:0]        pixRgb,
  output logic               pixValid,
  input  logic               pixReady
);

  strobe_t    strobe;
  logic [2:0] depthCode;
  depth_e     kind;

  assign kind = decodeDepth(depthCode);

  pxe_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .depthCode (depthCode),
    .inValid   (inValid),
    .pixReady  (pixReady),
    .inReady   (inReady),
    .pixValid  (pixValid),
    .strobe    (strobe)
  );

  pxe_datapath #(.PAL_AW(PAL_AW), .PWORD_W(PWORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .palWrEn   (palWrEn),
    .palWrAddr (palWrAddr),
    .palWrData (palWrData),
    .inData    (inData),
    .tftMode   (tftMode),
    .strobe    (strobe),
    .depthCode (depthCode),
    .pixRgb    (pixRgb)
  );

  // R9: a stalled pixel stays offered and unchanged
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && !pixReady && !palWrEn |=> pixValid && $stable(pixRgb));

  // R6: palette-derived and 4:4:4 pixels carry zero low nibbles
  p_low_nibbles_r6: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && !((kind == DEP_16) && tftMode) |->
      (pixRgb[19:16] == 4'h0) && (pixRgb[11:8] == 4'h0) && (pixRgb[3:0] == 4'h0));

endmodule

// File: tb/depth_expander_tb.sv
`timescale 1ns/1ps
module depth_expander_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        palWrEn = 1'b0;
  logic [7:0]  palWrAddr = 8'h00;
  logic [15:0] palWrData = 16'h0000;
  logic        tftMode = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [23:0] pixRgb;
  logic        pixValid;
  logic        pixReady;

  int total = 0;
  int bad = 0;
  int stalls = 0;
  int sawValid = 0;
  int readyMode = 0;
  bit finished = 0;
  logic [7:0]  lfsr = 8'h5a;
  logic [11:0] palM [256];
  logic [23:0] expQ [$];
  string curTag = "R10";

  always #2 clk = ~clk;

  depth_expander u_dut (
    .clk(clk), .rstN(rstN), .palWrEn(palWrEn), .palWrAddr(palWrAddr),
    .palWrData(palWrData), .tftMode(tftMode), .inData(inData),
    .inValid(inValid), .inReady(inReady), .pixRgb(pixRgb),
    .pixValid(pixValid), .pixReady(pixReady)
  );

  function automatic logic [23:0] x444(input logic [11:0] c);
    return {c[11:8], 4'h0, c[7:4], 4'h0, c[3:0], 4'h0};
  endfunction

  function automatic logic [23:0] x565(input logic [15:0] h);
    return {h[15:11], 3'b0, h[10:5], 2'b0, h[4:0], 3'b0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // sink: samples away from the clock edge, random or constant readiness
  initial begin
    pixReady = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pixReady = (readyMode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
      if (pixValid) sawValid++;
      if (pixValid && pixReady) begin
        if (expQ.size() == 0) check(1'b0, {curTag, " unexpected pixel"}, pixRgb, 24'h0);
        else begin
          logic [23:0] e;
          e = expQ.pop_front();
          check(pixRgb == e, curTag, pixRgb, e);
        end
      end
    end
  end

  task automatic palWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    palWrEn = 1'b1; palWrAddr = a; palWrData = d;
    palM[a] = d[11:0];
    @(negedge clk);
    palWrEn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1; inData = b;
    #1;
    while (!inReady) begin
      stalls++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic endStream();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n;
    endStream();
    n = 0;
    while ((expQ.size() != 0 || pixValid) && n < 4000) begin
      @(negedge clk); n++;
    end
    #1;
    check(expQ.size() == 0 && !pixValid, {tag, " all pixels delivered"}, 24'(expQ.size()), 24'h0);
    expQ.delete();
  endtask

  task automatic setCode(input logic [2:0] c);
    palWrite(8'h00, {1'b0, c, 12'h0a5});
  endtask

  task automatic run16(input logic [2:0] code, input bit tft, input int count, input string tag);
    setCode(code);
    tftMode = tft;
    curTag = tag;
    for (int i = 0; i < count; i++) begin
      logic [15:0] h;
      h = 16'((i * 40503 + 11) ^ (i << 8));
      expQ.push_back(tft ? x565(h) : x444(h[11:0]));
      sendByte(h[7:0]);
      sendByte(h[15:8]);
    end
    drain(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: reset state, code 0 so bytes are accepted
    check(pixValid == 1'b0, "R10 pixValid after reset", 24'(pixValid), 24'h0);
    check(inReady == 1'b1, "R10 inReady with code 0 after reset", 24'(inReady), 24'h1);

    for (int i = 1; i < 256; i++) palWrite(8'(i), 16'((i * 149 + 7) & 12'hfff) | 16'h7000);

    // R2: code 0 takes bytes and emits nothing
    setCode(3'd0);
    curTag = "R2";
    stalls = 0; sawValid = 0;
    for (int i = 0; i < 6; i++) sendByte(8'(i * 37));
    endStream();
    repeat (10) @(negedge clk);
    check(stalls == 0, "R2 bytes accepted immediately", 24'(stalls), 24'h0);
    check(sawValid == 0, "R2 no pixel", 24'(sawValid), 24'h0);

    // R3 / R6: 2 bpp sweep with random backpressure
    setCode(3'd1);
    readyMode = 1;
    curTag = "R3/R6 2bpp";
    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < 4; k++) expQ.push_back(x444(palM[(b >> (2 * k)) & 3]));
      sendByte(8'(b));
    end
    drain("R3/R9 2bpp");

    // R4: 4 bpp sweep
    setCode(3'd2);
    curTag = "R4/R6 4bpp";
    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < 2; k++) expQ.push_back(x444(palM[(b >> (4 * k)) & 15]));
      sendByte(8'(b));
    end
    drain("R4/R9 4bpp");

    // R5 / R11: 8 bpp sweep at full rate
    setCode(3'd3);
    readyMode = 0;
    curTag = "R5/R6 8bpp";
    stalls = 0;
    for (int b = 0; b < 256; b++) begin
      expQ.push_back(x444(palM[b]));
      sendByte(8'(255 - b));
      expQ[expQ.size() - 1] = x444(palM[255 - b]);
    end
    check(stalls == 0, "R11 no input stall at 8bpp", 24'(stalls), 24'h0);
    drain("R5 8bpp");

    // R7 / R8 / R9: 16 bpp both decodings under backpressure
    readyMode = 1;
    run16(3'd4, 1'b0, 300, "R7 16bpp 4:4:4");
    run16(3'd7, 1'b1, 300, "R8 16bpp 5:6:5");
    // R1: remaining codes also select 16 bpp
    run16(3'd5, 1'b1, 20, "R1 code5");
    run16(3'd6, 1'b0, 20, "R1 code6");

    // R7: a single low byte alone yields no pixel
    setCode(3'd4);
    sawValid = 0;
    sendByte(8'h3c);
    endStream();
    repeat (6) @(negedge clk);
    check(sawValid == 0, "R7 lone byte no pixel", 24'(sawValid), 24'h0);
    curTag = "R7 completed pair";
    tftMode = 1'b0;
    expQ.push_back(x444({4'h1, 8'h3c}));
    sendByte(8'h01);
    drain("R7 pair");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule